// File: doc/BRIEF.md
# Serial Read Cascade Token Controller

This block is the per-device read controller of a parallel-in, serial-out word buffer that can share one serial data line and one serial clock with other identical devices. It runs on the serial clock. It walks a bit counter across the word presented by the local buffer, and tells the buffer when each bit is taken (`shift_en`) and when the whole word is consumed (`word_done`). It also decides whether this device may drive the shared line (`ser_oe`).

The operating mode is captured while reset is held. If the expansion input is high during reset, the device runs standalone. It then always owns the line and its expansion output repeats the local almost-empty/almost-full flag. If the expansion input is low during reset, the device joins a ring. In the ring, a read token travels as a one-clock pulse from each device's expansion output to the next device's expansion input. The device sampled with a low first-load input at reset holds the token first. A token holder with no word keeps the token until it has shifted a word out. The bit order, least or most significant first, is taken from the direction input at the first bit of each word and held for the rest of that word.

Top module: `serial_cascade_ctrl`

## Requirements
- R1: While `rst` is high, `ser_oe`, `shift_en`, `word_done` and `chain_out` are all 0.
- R2: If `chain_in` is 1 on the last clock edge of reset, the device is standalone. After reset, `chain_out` equals `aeaf_in` and `ser_oe` stays 1.
- R3: In ring mode, a device reset with `first_load_n` = 0 owns the token and starts shifting in the first cycle after reset in which `word_avail` is 1. A device reset with `first_load_n` = 1 neither drives nor shifts until `chain_in` goes high.
- R4: With `msb_first` = 0, bit k of the word (k = 0 first) is presented in the k-th cycle of the word. With `msb_first` = 1, bit WORD_W-1-k is presented. The value used is the one present in the word's first bit cycle; later changes have no effect until the next word.
- R5: In ring mode, `chain_out` is 1 for exactly the one cycle that follows the clock edge that shifts the last bit of a word. From that cycle on, the device neither drives nor shifts until `chain_in` returns the token.
- R6: In ring mode, in a cycle where `chain_in` is 1 and `word_avail` is 1, the device drives the first bit of its word (`ser_oe` = 1, `shift_en` = 1) in that same cycle.
- R7: A ring device that holds the token while `word_avail` is 0 keeps `ser_oe`, `shift_en` and `chain_out` at 0 and keeps the token. It shifts as soon as a word becomes available.
- R8: `shift_en` is 1 in every cycle whose closing edge takes a bit. `word_done` is 1 only in the cycle of the last bit of a word.
- R9: A standalone device with no word keeps driving `ser_out` at the value of the last bit it shifted.
- R10: In ring mode, `ser_oe` is 1 only in cycles where the device is shifting a bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial shift clock |
| rst | input | 1 | Synchronous active-high reset; mode and first-load are captured while high |
| first_load_n | input | 1 | Low at reset marks the device that holds the token first |
| chain_in | input | 1 | Expansion input: token pulse from the previous device, or tied high for standalone |
| msb_first | input | 1 | Bit order: 1 = most significant bit first |
| word_avail | input | 1 | Local buffer has a word at its head |
| word_data | input | WORD_W | Head word of the local buffer |
| aeaf_in | input | 1 | Local almost-empty/almost-full flag (standalone only) |
| ser_out | output | 1 | Serial data bit for the shared line |
| ser_oe | output | 1 | Drive enable for the shared line |
| shift_en | output | 1 | A bit is taken at the coming clock edge |
| word_done | output | 1 | The bit taken at the coming edge is the last of the word |
| chain_out | output | 1 | Expansion output: token pulse in ring mode, `aeaf_in` in standalone mode |

## Verification
A wrong bit counter shows up within one word. The serial stream then carries bits in the wrong order, or `word_done` and the token pulse arrive on the wrong cycle. A token state that is lost or duplicated shows up in the next cycle as a device that drives while it should be silent, or that stays silent when the token arrives. A mode captured wrongly at reset makes `chain_out` follow the flag where it should pulse, or the reverse, from the first cycle after reset. The bench sweeps several word patterns in both bit orders, returns the token through the ring input, and compares every bit cycle against values computed from the word.

// File: rtl/ser_cascade_pkg.sv
package ser_cascade_pkg;

    typedef enum logic {
        MODE_RING = 1'b0,
        MODE_SOLO = 1'b1
    } cas_mode_e;

    typedef struct packed {
        logic own;
        logic pulse;
    } tok_state_t;

    function automatic int unsigned bit_pick(input int unsigned cnt,
                                             input logic msb,
                                             input int unsigned width);
        return msb ? (width - 1 - cnt) : cnt;
    endfunction

endpackage

// File: rtl/cas_mode_latch.sv
module cas_mode_latch
    import ser_cascade_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      chain_in,
    output cas_mode_e mode
);
    always_ff @(posedge clk) begin
        if (rst)
            mode <= chain_in ? MODE_SOLO : MODE_RING;
    end
endmodule

// File: rtl/cas_bit_seq.sv
module cas_bit_seq
    import ser_cascade_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int CNT_W  = $clog2(WORD_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             msb_first,
    output logic             last,
    output logic [CNT_W-1:0] idx
);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             dir_q;
    logic             dir_eff;

    assign dir_eff = (cnt_q == '0) ? msb_first : dir_q;
    assign last    = (cnt_q == LAST_IDX);
    assign idx     = CNT_W'(bit_pick(int'(cnt_q), dir_eff, WORD_W));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            dir_q <= 1'b0;
        end else if (step) begin
            cnt_q <= last ? '0 : cnt_q + 1'b1;
            if (cnt_q == '0)
                dir_q <= msb_first;
        end
    end
endmodule

// File: rtl/cas_token.sv
module cas_token
    import ser_cascade_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  cas_mode_e mode,
    input  logic      first_load_n,
    input  logic      chain_in,
    input  logic      word_avail,
    input  logic      last,
    output logic      go,
    output logic      tok_pulse
);
    tok_state_t st_q;
    logic       own_eff;
    logic       ring;

    assign ring      = (mode == MODE_RING);
    assign own_eff   = ring ? (st_q.own | chain_in) : 1'b1;
    assign go        = ~rst & own_eff & word_avail;
    assign tok_pulse = st_q.pulse;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.own   <= ~first_load_n;
            st_q.pulse <= 1'b0;
        end else begin
            st_q.pulse <= ring & go & last;
            st_q.own   <= ring & own_eff & ~(go & last);
        end
    end
endmodule

// File: rtl/cas_line_drv.sv
module cas_line_drv
    import ser_cascade_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int CNT_W  = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  cas_mode_e         mode,
    input  logic              go,
    input  logic [WORD_W-1:0] word_data,
    input  logic [CNT_W-1:0]  idx,
    output logic              ser_out,
    output logic              ser_oe
);
    logic cur_bit;
    logic hold_q;

    assign cur_bit = word_data[idx];
    assign ser_out = go ? cur_bit : hold_q;
    assign ser_oe  = rst ? 1'b0 : ((mode == MODE_SOLO) ? 1'b1 : go);

    always_ff @(posedge clk) begin
        if (rst)
            hold_q <= 1'b0;
        else if (go)
            hold_q <= cur_bit;
    end
endmodule

// File: rtl/serial_cascade_ctrl.sv
module serial_cascade_ctrl
    import ser_cascade_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              first_load_n,
    input  logic              chain_in,
    input  logic              msb_first,
    input  logic              word_avail,
    input  logic [WORD_W-1:0] word_data,
    input  logic              aeaf_in,
    output logic              ser_out,
    output logic              ser_oe,
    output logic              shift_en,
    output logic              word_done,
    output logic              chain_out
);
    localparam int CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;

    cas_mode_e        mode;
    logic             solo_mode;
    logic             go;
    logic             last;
    logic             tok_pulse;
    logic [CNT_W-1:0] idx;

    cas_mode_latch u_mode (
        .clk      (clk),
        .rst      (rst),
        .chain_in (chain_in),
        .mode     (mode)
    );

    cas_bit_seq #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .step      (go),
        .msb_first (msb_first),
        .last      (last),
        .idx       (idx)
    );

    cas_token u_tok (
        .clk          (clk),
        .rst          (rst),
        .mode         (mode),
        .first_load_n (first_load_n),
        .chain_in     (chain_in),
        .word_avail   (word_avail),
        .last         (last),
        .go           (go),
        .tok_pulse    (tok_pulse)
    );

    cas_line_drv #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_drv (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .go        (go),
        .word_data (word_data),
        .idx       (idx),
        .ser_out   (ser_out),
        .ser_oe    (ser_oe)
    );

    assign solo_mode = (mode == MODE_SOLO);
    assign shift_en  = go;
    assign word_done = go & last;
    assign chain_out = rst ? 1'b0 : (solo_mode ? aeaf_in : tok_pulse);

endmodule

// File: rtl/cas_checker.sv
module cas_checker (
    input logic clk,
    input logic rst,
    input logic solo_mode,
    input logic word_avail,
    input logic ser_oe,
    input logic shift_en,
    input logic word_done,
    input logic chain_out
);
    always @(negedge clk) begin
        if (rst === 1'b1)
            p_reset_quiet_r1: assert (!ser_oe && !shift_en && !word_done && !chain_out);
    end

    p_solo_drives_r2: assert property (@(posedge clk) disable iff (rst)
        solo_mode |-> ser_oe);

    p_pulse_after_last_r5: assert property (@(posedge clk) disable iff (rst)
        (!solo_mode && word_done) |=> chain_out);

    p_pulse_single_r5: assert property (@(posedge clk) disable iff (rst)
        (!solo_mode && chain_out) |=> !chain_out);

    p_release_r5: assert property (@(posedge clk) disable iff (rst)
        (!solo_mode && word_done) |=> !shift_en);

    p_no_word_no_shift_r7: assert property (@(posedge clk) disable iff (rst)
        !word_avail |-> !shift_en);

    p_done_is_shift_r8: assert property (@(posedge clk) disable iff (rst)
        word_done |-> shift_en);

    p_ring_oe_r10: assert property (@(posedge clk) disable iff (rst)
        (!solo_mode && ser_oe) |-> shift_en);
endmodule

bind serial_cascade_ctrl cas_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .solo_mode  (solo_mode),
    .word_avail (word_avail),
    .ser_oe     (ser_oe),
    .shift_en   (shift_en),
    .word_done  (word_done),
    .chain_out  (chain_out)
);

// File: tb/serial_cascade_ctrl_test.sv
module serial_cascade_ctrl_test;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         first_load_n = 1'b0;
    logic         chain_in = 1'b0;
    logic         msb_first = 1'b0;
    logic         word_avail = 1'b0;
    logic [W-1:0] word_data = '0;
    logic         aeaf_in = 1'b0;
    logic         ser_out, ser_oe, shift_en, word_done, chain_out;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    serial_cascade_ctrl #(.WORD_W(W)) uut (
        .clk(clk), .rst(rst), .first_load_n(first_load_n), .chain_in(chain_in),
        .msb_first(msb_first), .word_avail(word_avail), .word_data(word_data),
        .aeaf_in(aeaf_in), .ser_out(ser_out), .ser_oe(ser_oe),
        .shift_en(shift_en), .word_done(word_done), .chain_out(chain_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset(input logic fl_n, input logic ch);
        @(negedge clk);
        rst = 1'b1; first_load_n = fl_n; chain_in = ch; word_avail = 1'b0;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk); #1;
            chk("R1 oe", ser_oe, 0);
            chk("R1 shift", shift_en, 0);
            chk("R1 chain_out", chain_out, 0);
        end
        rst = 1'b0;
    endtask

    // One word; solo keeps chain_in high, give drives the token in cycle 0
    task automatic run_word(input logic [W-1:0] d, input logic dir, input logic flip,
                            input logic give, input logic solo);
        for (int i = 0; i < W; i++) begin
            @(negedge clk);
            word_data = d; word_avail = 1'b1;
            msb_first = (flip && i >= 1) ? ~dir : dir;
            chain_in = solo ? 1'b1 : (give && i == 0);
            #1;
            chk("R8 shift_en", shift_en, 1);
            chk("R6/R10 oe", ser_oe, 1);
            chk("R4 bit", ser_out, d[dir ? (W-1-i) : i]);
            chk("R8 word_done", word_done, (i == W-1) ? 1 : 0);
        end
        if (!solo) begin
            @(negedge clk); chain_in = 1'b0; #1;
            chk("R5 pulse", chain_out, 1);
            chk("R5 released oe", ser_oe, 0);
            chk("R5 released shift", shift_en, 0);
            @(negedge clk); #1;
            chk("R5 pulse width", chain_out, 0);
            chk("R5 still idle", ser_oe, 0);
        end
    endtask

    initial begin
        #(8 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual 0 expected 1 (run finished)");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [W-1:0] pats [5];
        pats[0] = 16'h0001; pats[1] = 16'h8000; pats[2] = 16'hA5C3;
        pats[3] = 16'h1234; pats[4] = 16'hFFFE;

        // Ring mode, lead device (R3, R7, R4, R5, R6)
        do_reset(1'b0, 1'b0);
        for (int c = 0; c < 3; c++) begin
            @(negedge clk); word_avail = 1'b0; #1;
            chk("R7 empty oe", ser_oe, 0);
            chk("R7 empty shift", shift_en, 0);
            chk("R7 no pulse", chain_out, 0);
        end
        run_word(pats[2], 1'b0, 1'b0, 1'b0, 1'b0);   // R3 lead starts
        for (int p = 0; p < 5; p++)
            for (int dr = 0; dr < 2; dr++)
                run_word(pats[p], dr[0], (p % 2) == 1, 1'b1, 1'b0);

        // Token arrives with empty buffer: kept (R7)
        @(negedge clk); word_avail = 1'b0; chain_in = 1'b1; #1;
        chk("R7 token empty oe", ser_oe, 0);
        chk("R7 token empty shift", shift_en, 0);
        for (int c = 0; c < 3; c++) begin
            @(negedge clk); chain_in = 1'b0; #1;
            chk("R7 hold oe", ser_oe, 0);
            chk("R7 hold no pulse", chain_out, 0);
        end
        run_word(pats[3], 1'b1, 1'b0, 1'b0, 1'b0);

        // Ring mode, non-lead device (R3)
        do_reset(1'b1, 1'b0);
        for (int c = 0; c < 4; c++) begin
            @(negedge clk); word_avail = 1'b1; word_data = pats[2]; #1;
            chk("R3 nonlead oe", ser_oe, 0);
            chk("R3 nonlead shift", shift_en, 0);
        end
        run_word(pats[2], 1'b1, 1'b0, 1'b1, 1'b0);

        // Standalone mode (R2, R9)
        do_reset(1'b1, 1'b1);
        for (int c = 0; c < 4; c++) begin
            @(negedge clk); chain_in = 1'b1; aeaf_in = c[0]; word_avail = 1'b0; #1;
            chk("R2 flag follows", chain_out, c[0]);
            chk("R2 solo oe", ser_oe, 1);
            chk("R2 solo no shift", shift_en, 0);
        end
        aeaf_in = 1'b0;
        run_word(pats[3], 1'b0, 1'b1, 1'b0, 1'b1);
        run_word(pats[2], 1'b1, 1'b0, 1'b0, 1'b1);
        for (int c = 0; c < 3; c++) begin
            @(negedge clk); word_avail = 1'b0; word_data = ~pats[2]; #1;
            chk("R9 oe held", ser_oe, 1);
            chk("R9 last bit held", ser_out, pats[2][0]);
            chk("R2 no pulse solo", chain_out, 0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule